// File: doc/BRIEF.md
# Shift control full-adder merger

This block folds an additional rotation amount into a set of precomputed control bits for a log-depth shift network. The base control bits arrive grouped by stage: the first stage carries half as many bits as the network has lanes, and each later stage carries half as many as the one before it, down to a single bit. The block adds an unsigned stride into them and returns corrected control bits. The shift network that consumes these bits sees the same rotation it would see if the stride had been part of the original control computation.

The block is built as a tree of full adders. Each stage adds one stride bit into every one of its cells. Carries flow from the narrow stages toward the wide ones, and every carry of a narrower stage feeds two cells of the next wider stage. The network is purely combinational and has no clock. The longest path crosses one full adder per stage.

Top module: `scm_merge`

## Requirements
- R1: All stages travel in one vector of N-1 bits, where N = 2^LOGN. Stage i has 2^(LOGN-1-i) cells and starts at bit N - 2^(LOGN-i), with cell 0 at its lowest bit. Stage 0 therefore occupies bits N/2-1..0, and the single cell of the last stage sits at bit N-2. Inputs and outputs use the same packing.
- R2: Each output cell equals the XOR of its input cell, the stride bit of its stage, and its carry-in.
- R3: Stage i adds stride bit LOGN-1-i, so the stride LSB goes to the one-cell stage and the stride MSB goes to stage 0.
- R4: The carry-in of the one-cell stage is zero, so output bit N-2 equals input bit N-2 XOR stride bit 0.
- R5: For stage i below LOGN-1, cell j takes its carry-in from the carry-out of stage i+1, cell j mod 2^(LOGN-2-i). A carry-out is the majority of the cell's input bit, its stride bit and its carry-in. Carry-outs of stage 0 are dropped.
- R6: With a zero stride, the output equals the input for any input pattern.
- R7: With LOGN=4 and stride 11, the input stages (cell 0 first) [0,0,1,0,1,1,0,1], [0,1,1,0], [0,1], [0] give [1,0,0,1,0,1,1,0], [0,0,1,1], [1,0], [1].
- R8: The output follows any input change with no clock edge, since the block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_in | input | 2^LOGN-1 | Base control bits of all stages, packed as in R1 |
| stride | input | LOGN | Unsigned extra rotation amount |
| ctl_out | output | 2^LOGN-1 | Corrected control bits, same packing |

## Verification
The bench builds two instances, one with LOGN=4 and one with LOGN=10. At LOGN=4 it can apply the worked case and every stride value against many random control patterns, so every carry path of a small tree is exercised. At LOGN=10 the bench uses random strides and patterns over 1023 bits. This reaches long carry chains through ten stages and the modulo fan-out at wide stages, where an indexing error would stay hidden at small sizes.

// File: rtl/scm_pkg.sv
package scm_pkg;

  // cells in stage i of a LOGN-stage tree
  function automatic int stage_width(input int logn, input int i);
    return 1 << (logn - 1 - i);
  endfunction

  // bit offset of stage i inside the flat vector
  function automatic int stage_off(input int logn, input int i);
    return (1 << logn) - (1 << (logn - i));
  endfunction

  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (ci & (a ^ b));
  endfunction

endpackage

// File: rtl/scm_fa.sv
module scm_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  import scm_pkg::*;

  always_comb begin
    s  = fa_sum(a, b, ci);
    co = fa_carry(a, b, ci);
    if (!$isunknown({a, b, ci}))
      AST_FA_ARITH: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {1'b0, ci})); // R5
  end
endmodule

// File: rtl/scm_stage.sv
module scm_stage #(
  parameter int LOGN  = 4,
  parameter int STAGE = 0,
  localparam int W       = 1 << (LOGN - 1 - STAGE),
  localparam bit IS_LAST = (STAGE == LOGN - 1),
  localparam int CW      = IS_LAST ? 1 : W / 2
) (
  input  logic [W-1:0]  base,
  input  logic          stride_bit,
  input  logic [CW-1:0] cin_src,
  output logic [W-1:0]  merged,
  output logic [W-1:0]  cout
);
  logic [W-1:0] cin_w;   // carry-in seen by each cell

  for (genvar j = 0; j < W; j++) begin : g_cell
    localparam int SRC = j % CW;
    assign cin_w[j] = IS_LAST ? 1'b0 : cin_src[SRC];
    scm_fa u_fa (
      .a  (base[j]),
      .b  (stride_bit),
      .ci (cin_w[j]),
      .s  (merged[j]),
      .co (cout[j])
    );
  end

  always_comb begin
    if (!$isunknown({base, stride_bit, cin_w, merged}))
      AST_SUM_PARITY: assert ((merged ^ base ^ {W{stride_bit}}) == cin_w); // R2
    if (IS_LAST && !$isunknown(cin_src))
      AST_LAST_CIN_ZERO: assert (cin_src == '0); // R4
  end
endmodule

// File: rtl/scm_merge.sv
module scm_merge #(
  parameter int LOGN = 4,
  localparam int N    = 1 << LOGN,
  localparam int FLAT = N - 1
) (
  input  logic [FLAT-1:0] ctl_in,
  input  logic [LOGN-1:0] stride,
  output logic [FLAT-1:0] ctl_out
);
  import scm_pkg::*;

  logic [FLAT-1:0] carry_all;   // carry-outs, same packing as the data

  for (genvar i = 0; i < LOGN; i++) begin : g_stage
    localparam int OFF = stage_off(LOGN, i);
    localparam int W   = stage_width(LOGN, i);
    if (i == LOGN - 1) begin : g_last
      scm_stage #(.LOGN(LOGN), .STAGE(i)) u_stage (
        .base       (ctl_in[OFF +: W]),
        .stride_bit (stride[LOGN-1-i]),
        .cin_src    (1'b0),
        .merged     (ctl_out[OFF +: W]),
        .cout       (carry_all[OFF +: W])
      );
    end else begin : g_inner
      localparam int NOFF = stage_off(LOGN, i + 1);
      localparam int NW   = stage_width(LOGN, i + 1);
      scm_stage #(.LOGN(LOGN), .STAGE(i)) u_stage (
        .base       (ctl_in[OFF +: W]),
        .stride_bit (stride[LOGN-1-i]),
        .cin_src    (carry_all[NOFF +: NW]),
        .merged     (ctl_out[OFF +: W]),
        .cout       (carry_all[OFF +: W])
      );
    end
  end

  // dropped stage-0 carries can only be set when data or stride MSB is set
  always_comb begin
    if (!$isunknown({ctl_in, stride, ctl_out, carry_all})) begin
      AST_ZERO_STRIDE_PASS: assert (stride != '0 || ctl_out == ctl_in); // R6
      AST_DROP_CARRY_SRC: assert ((carry_all[N/2-1:0] & ~ctl_in[N/2-1:0] & {(N/2){~stride[LOGN-1]}}) == '0); // R5
      AST_LAST_BIT: assert (ctl_out[N-2] == (ctl_in[N-2] ^ stride[0])); // R3
    end
  end
endmodule

// File: tb/scm_merge_tb.sv
module scm_merge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 1023;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [14:0]  s_in, s_out;
  logic [3:0]   s_str;
  logic [1022:0] b_in, b_out;
  logic [9:0]   b_str;

  scm_merge #(.LOGN(4))  u_dut     (.ctl_in(s_in), .stride(s_str), .ctl_out(s_out));
  scm_merge #(.LOGN(10)) u_dut_big (.ctl_in(b_in), .stride(b_str), .ctl_out(b_out));

  // bench model: walk stages from narrow to wide, carry by modulo index
  function automatic logic [MAXW-1:0] model(input int logn, input logic [MAXW-1:0] din,
                                            input int str);
    logic [MAXW-1:0] res = '0;
    logic [MAXW-1:0] cy  = '0;
    int n = 1 << logn;
    for (int i = logn - 1; i >= 0; i--) begin
      int w   = 1 << (logn - 1 - i);
      int off = n - 2 * w;
      logic sb = 1'(str >> (logn - 1 - i));
      for (int j = 0; j < w; j++) begin
        logic ci, a;
        a  = din[off + j];
        ci = 1'b0;
        if (i != logn - 1) ci = cy[(n - w) + (j % (w / 2))];
        res[off + j] = a ^ sb ^ ci;
        cy[off + j]  = (a & sb) | (a & ci) | (sb & ci);
      end
    end
    return res;
  endfunction

  function automatic logic [MAXW-1:0] rnd_vec();
    logic [MAXW-1:0] v = '0;
    for (int k = 0; k < 32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic check(input string req, input logic [MAXW-1:0] act, input logic [MAXW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_small(input string req, input logic [14:0] din, input int str);
    s_in  = din;
    s_str = 4'(str);
    #1;
    check(req, MAXW'(s_out), model(4, MAXW'(din), str));
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    s_in = '0; s_str = '0; b_in = '0; b_str = '0;
    #(CLK_PERIOD/2);
    // R7: worked case, hard-coded expectation
    s_in = {1'b0, 2'b10, 4'b0110, 8'hB4};
    s_str = 4'd11;
    #1;
    check("R7", MAXW'(s_out), MAXW'({1'b1, 2'b01, 4'b1100, 8'h69}));
    // R8: change input without any clock edge, output follows at once
    s_str = 4'd0;
    #1;
    check("R8", MAXW'(s_out), MAXW'({1'b0, 2'b10, 4'b0110, 8'hB4}));
    // R6: zero stride passes patterns through
    for (int k = 0; k < 8; k++) begin
      logic [14:0] p = 15'($urandom());
      s_in = p; s_str = 4'd0; #1;
      check("R6", MAXW'(s_out), MAXW'(p));
    end
    // R4/R3: last stage sees stride LSB with carry-in zero
    s_in = 15'h4000; s_str = 4'd1; #1;
    check("R4", MAXW'(s_out[14]), MAXW'(1'b0));
    // R3: stride MSB alone, zero data, only stage 0 flips (bits 7..0)
    s_in = '0; s_str = 4'd8; #1;
    check("R3", MAXW'(s_out), MAXW'(15'h00FF));
    // R1: stride bit 1 alone reaches stage 2 at bits 13..12
    s_in = '0; s_str = 4'd2; #1;
    check("R1", MAXW'(s_out), MAXW'(15'h3000));
    // R5: all-ones data with stride 1 ripples carries through every stage
    run_small("R5", 15'h7FFF, 1);
    run_small("R5", 15'h7FFF, 15);
    // R2/R5: every stride against random patterns
    for (int st = 0; st < 16; st++)
      for (int k = 0; k < 8; k++)
        run_small("R2", 15'($urandom()), st);
    // R1/R5: wide tree, random sample
    for (int k = 0; k < 200; k++) begin
      logic [MAXW-1:0] p = rnd_vec();
      int st = int'($urandom() % 1024);
      b_in = p; b_str = 10'(st); #1;
      check("R5", b_out, model(10, p, st));
    end
    b_in = '1; b_str = 10'd1; #1;
    check("R1", b_out, model(10, '1, 1));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule